// File: doc/BRIEF.md
# Adaptive-Resonance Binary Clustering Engine

The block sorts binary vectors into a fixed set of learned categories. A host places an N-bit vector on `pattern` and pulses `start` while the engine is idle. Every category node scores the vector through its bottom-up weights. The engine then looks for a node in a loop. Each pass takes the best node that is still eligible. It ANDs the vector with that node's stored template and checks whether enough of the vector's set bits survive. A node that fails is barred for the rest of the vector and the loop repeats. A node that passes refines its template and weights, and the engine reports its index. If no eligible node is left, the vector is reported as unclustered.

Each pass of the loop takes one clock cycle, so the latency of a vector is one more than the number of nodes it rejected. Templates only ever lose bits, so the categories settle down as vectors arrive. Control over repeated presentations belongs to the host.

Top module: `art_cluster_engine`

## Requirements
- R1: After reset `busy`, `done` and `cluster_ok` are 0. Every template bit is 1 and every bottom-up weight equals floor(256/(1+N_BITS)), in unsigned fixed point with 8 fractional bits. As a result, the first nonzero vector after reset is taken by node 0 in one search cycle.
- R2: The score of a node is the sum of its bottom-up weights over the bit positions where the latched vector is 1.
- R3: Each search cycle picks the node with the highest score among the nodes not barred. On equal scores the lowest index wins.
- R4: The match is the vector ANDed with the chosen node's template. The node passes when 10 times popcount(match) is at least 9 times popcount(vector).
- R5: A node that fails is barred for the rest of the current vector. `done` rises at the edge that ends the last search cycle, which is rejections+1 clock edges after the edge that accepted `start`.
- R6: On a pass the template becomes the match. Each bottom-up weight becomes floor(512/(1+popcount(match))) where the match bit is 1, and 0 elsewhere. `cluster_ok` is 1 and `cluster_id` carries the node index.
- R7: When every node is barred, `done` rises with `cluster_ok` at 0 and no weight or template changes.
- R8: An all-zero vector skips the search. `done` rises with `cluster_ok` at 0 at the same edge that accepts `start`.
- R9: The barred set is emptied whenever a new vector is accepted.
- R10: `start` is ignored while `busy` is 1. The vector in progress and its result are unaffected.
- R11: A template bit that has become 0 never returns to 1 without a reset.
- R12: `done` is a single-cycle strobe and is never high together with `busy`. `busy` is high from the acceptance of a nonzero vector until its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept `pattern` when idle |
| pattern | input | N_BITS | Binary input vector |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| cluster_ok | output | 1 | Vector was placed in a category |
| cluster_id | output | clog2(N_NODES) | Index of the learning node |

## Verification
The assertions assume that `start` is a clean synchronous level. They also assume that the host reads the result only in the cycle `done` is high. Nothing is assumed about when `start` arrives, so the checks on barring and acceptance must hold even when `start` stays high through a search. The stimulus deliberately holds `start` high with a different vector during busy cycles. It draws vectors from a handful of random prototypes with bits randomly dropped, so both passes and full rejection happen often. It also resets periodically so that fresh templates keep being claimed.

// File: rtl/ac_pkg.sv
package ac_pkg;

    localparam int FRAC_BITS = 8;
    localparam int LEARN_L   = 2;
    localparam int VIG_NUM   = 9;
    localparam int VIG_DEN   = 10;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_SEARCH
    } ac_state_e;

    typedef struct packed {
        logic any_left;
        logic vig_pass;
    } ac_verdict_t;

    function automatic int unsigned ones(input logic [63:0] v);
        int unsigned c = 0;
        for (int i = 0; i < 64; i++) c += int'(v[i]);
        return c;
    endfunction

    function automatic int unsigned init_weight(input int unsigned n);
        return (32'd1 << FRAC_BITS) / (n + 1);
    endfunction

    function automatic int unsigned learn_weight(input int unsigned k);
        return (LEARN_L << FRAC_BITS) / (LEARN_L - 1 + k);
    endfunction

endpackage

// File: rtl/ac_node.sv
module ac_node #(
    parameter int N_BITS = 8,
    parameter int WW     = 10,
    parameter int SW     = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_BITS-1:0] vec,
    input  logic              learn,
    input  logic [N_BITS-1:0] match,
    input  logic [WW-1:0]     new_w,
    output logic [SW-1:0]     score,
    output logic [N_BITS-1:0] templ
);
    localparam logic [WW-1:0] W_INIT = WW'(ac_pkg::init_weight(N_BITS));

    logic [WW-1:0] bu_w [N_BITS];

    always_ff @(posedge clk) begin
        if (rst) begin
            templ <= '1;
            for (int i = 0; i < N_BITS; i++) bu_w[i] <= W_INIT;
        end else if (learn) begin
            templ <= match;
            for (int i = 0; i < N_BITS; i++) bu_w[i] <= match[i] ? new_w : '0;
        end
    end

    always_comb begin
        score = '0;
        for (int i = 0; i < N_BITS; i++)
            if (vec[i]) score = score + SW'(bu_w[i]);
    end
endmodule

// File: rtl/ac_pick.sv
module ac_pick #(
    parameter int N_NODES = 4,
    parameter int SW      = 14,
    parameter int IW      = 2
) (
    input  logic [N_NODES*SW-1:0] scores,
    input  logic [N_NODES-1:0]    barred,
    output logic                  found,
    output logic [IW-1:0]         idx
);
    logic [SW-1:0] best;

    always_comb begin
        found = 1'b0;
        best  = '0;
        idx   = '0;
        for (int j = 0; j < N_NODES; j++) begin
            if (!barred[j] && (!found || scores[j*SW +: SW] > best)) begin
                found = 1'b1;
                best  = scores[j*SW +: SW];
                idx   = IW'(j);
            end
        end
    end
endmodule

// File: rtl/ac_vigil.sv
module ac_vigil #(
    parameter int N_BITS = 8,
    parameter int CW     = 4
) (
    input  logic [N_BITS-1:0] vec,
    input  logic [N_BITS-1:0] templ,
    output logic [N_BITS-1:0] match,
    output logic [CW-1:0]     match_cnt,
    output logic              pass
);
    int unsigned m_cnt;
    int unsigned s_cnt;

    always_comb begin
        match     = vec & templ;
        m_cnt     = ac_pkg::ones(64'(match));
        s_cnt     = ac_pkg::ones(64'(vec));
        match_cnt = CW'(m_cnt);
        pass      = (ac_pkg::VIG_DEN * m_cnt) >= (ac_pkg::VIG_NUM * s_cnt);
    end
endmodule

// File: rtl/art_cluster_engine.sv
module art_cluster_engine #(
    parameter int N_BITS  = 8,
    parameter int N_NODES = 4,
    localparam int IW     = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [N_BITS-1:0] pattern,
    output logic              busy,
    output logic              done,
    output logic              cluster_ok,
    output logic [IW-1:0]     cluster_id
);
    import ac_pkg::*;

    localparam int WW = FRAC_BITS + 2;
    localparam int CW = $clog2(N_BITS + 1);
    localparam int SW = WW + CW;

    ac_state_e              state;
    logic [N_BITS-1:0]      pat_q;
    logic [N_NODES-1:0]     inhibit_q;
    logic [N_NODES*SW-1:0]  score_flat;
    logic [N_NODES*N_BITS-1:0] td_flat;
    logic [N_BITS-1:0]      win_templ;
    logic [N_BITS-1:0]      match;
    logic [CW-1:0]          match_cnt;
    logic [IW-1:0]          win_idx;
    logic [WW-1:0]          wlut [N_BITS+1];
    ac_verdict_t            verdict;
    logic                   learn_now;

    // learning-rate lookup indexed by match popcount
    generate
        for (genvar k = 0; k <= N_BITS; k++) begin : g_lut
            assign wlut[k] = WW'(learn_weight(k));
        end
    endgenerate

    generate
        for (genvar j = 0; j < N_NODES; j++) begin : g_node
            ac_node #(.N_BITS(N_BITS), .WW(WW), .SW(SW)) u_node (
                .clk   (clk),
                .rst   (rst),
                .vec   (pat_q),
                .learn (learn_now && (win_idx == IW'(j))),
                .match (match),
                .new_w (wlut[match_cnt]),
                .score (score_flat[j*SW +: SW]),
                .templ (td_flat[j*N_BITS +: N_BITS])
            );
        end
    endgenerate

    ac_pick #(.N_NODES(N_NODES), .SW(SW), .IW(IW)) u_pick (
        .scores (score_flat),
        .barred (inhibit_q),
        .found  (verdict.any_left),
        .idx    (win_idx)
    );

    always_comb begin
        win_templ = '1;
        for (int j = 0; j < N_NODES; j++)
            if (win_idx == IW'(j)) win_templ = td_flat[j*N_BITS +: N_BITS];
    end

    ac_vigil #(.N_BITS(N_BITS), .CW(CW)) u_vigil (
        .vec       (pat_q),
        .templ     (win_templ),
        .match     (match),
        .match_cnt (match_cnt),
        .pass      (verdict.vig_pass)
    );

    assign learn_now = (state == ST_SEARCH) && verdict.any_left && verdict.vig_pass;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            pat_q      <= '0;
            inhibit_q  <= '0;
            busy       <= 1'b0;
            done       <= 1'b0;
            cluster_ok <= 1'b0;
            cluster_id <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        pat_q     <= pattern;
                        inhibit_q <= '0;
                        if (pattern == '0) begin
                            done       <= 1'b1;
                            cluster_ok <= 1'b0;
                            cluster_id <= '0;
                        end else begin
                            state <= ST_SEARCH;
                            busy  <= 1'b1;
                        end
                    end
                end
                ST_SEARCH: begin
                    if (!verdict.any_left) begin
                        state      <= ST_IDLE;
                        busy       <= 1'b0;
                        done       <= 1'b1;
                        cluster_ok <= 1'b0;
                        cluster_id <= '0;
                    end else if (verdict.vig_pass) begin
                        state      <= ST_IDLE;
                        busy       <= 1'b0;
                        done       <= 1'b1;
                        cluster_ok <= 1'b1;
                        cluster_id <= win_idx;
                    end else begin
                        inhibit_q[win_idx] <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ac_checker.sv
module ac_checker #(
    parameter int N_BITS  = 8,
    parameter int N_NODES = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      start,
    input logic [N_BITS-1:0]         pattern,
    input logic                      busy,
    input logic                      done,
    input logic                      cluster_ok,
    input logic [N_NODES-1:0]        inhibit,
    input logic [N_NODES*N_BITS-1:0] td_flat
);
    p_done_idle_r12: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_nonzero_goes_busy_r12: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && pattern != '0) |=> busy);

    p_zero_unclustered_r8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && pattern == '0) |=> (done && !cluster_ok));

    p_inhibit_cleared_r9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (inhibit == '0));

    p_one_bar_per_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($countones(inhibit) <= $countones($past(inhibit)) + 1));

    p_template_clear_only_r11: assert property (@(posedge clk) disable iff (rst)
        (td_flat & ~$past(td_flat)) == '0);

    p_no_learn_on_reject_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !cluster_ok) |-> (td_flat == $past(td_flat)));
endmodule

bind art_cluster_engine ac_checker #(.N_BITS(N_BITS), .N_NODES(N_NODES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .pattern    (pattern),
    .busy       (busy),
    .done       (done),
    .cluster_ok (cluster_ok),
    .inhibit    (inhibit_q),
    .td_flat    (td_flat)
);

// File: tb/art_cluster_engine_test.sv
`timescale 1ns/1ps
module art_cluster_engine_test;
    localparam int NB = 8;
    localparam int NN = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [NB-1:0] pattern = '0;
    logic          busy, done, cluster_ok;
    logic [1:0]    cluster_id;

    int checks = 0;
    int errors = 0;

    int unsigned m_bu [NN][NB];
    bit [NB-1:0] m_td [NN];

    art_cluster_engine #(.N_BITS(NB), .N_NODES(NN)) uut (
        .clk(clk), .rst(rst), .start(start), .pattern(pattern),
        .busy(busy), .done(done), .cluster_ok(cluster_ok), .cluster_id(cluster_id)
    );

    always #2.5 clk = ~clk;

    function automatic int pc(input bit [NB-1:0] v);
        int c = 0;
        for (int i = 0; i < NB; i++) c += int'(v[i]);
        return c;
    endfunction

    function automatic void model_reset();
        for (int j = 0; j < NN; j++) begin
            m_td[j] = '1;
            for (int i = 0; i < NB; i++) m_bu[j][i] = 256 / (1 + NB);   // R1
        end
    endfunction

    // Expected outcome per R2..R8; updates the model on learning
    function automatic void model_run(input bit [NB-1:0] s, output bit ok,
                                      output int id, output int lat);
        bit [NN-1:0] bar = '0;   // R9: fresh for each vector
        int rej = 0;
        ok = 0; id = 0;
        if (s == '0) begin lat = 0; return; end
        forever begin
            int best = -1; int bj = -1;
            for (int j = 0; j < NN; j++) begin
                int sc = 0;
                if (bar[j]) continue;
                for (int i = 0; i < NB; i++) if (s[i]) sc += int'(m_bu[j][i]);
                if (sc > best) begin best = sc; bj = j; end
            end
            if (bj < 0) begin lat = rej + 1; return; end
            begin
                bit [NB-1:0] x = s & m_td[bj];
                if (10 * pc(x) >= 9 * pc(s)) begin
                    m_td[bj] = x;
                    for (int i = 0; i < NB; i++)
                        m_bu[bj][i] = x[i] ? 512 / (1 + pc(x)) : 0;
                    ok = 1; id = bj; lat = rej + 1; return;
                end
                bar[bj] = 1'b1; rej++;
            end
        end
    endfunction

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        check(!busy && !done && !cluster_ok, "R1 reset outputs",
              {busy, done, cluster_ok}, 0);
    endtask

    task automatic run_vec(input bit [NB-1:0] p, input bit poke, input string tag);
        bit eok; int eid; int elat; int c;
        model_run(p, eok, eid, elat);
        @(negedge clk); start = 1'b1; pattern = p;
        @(negedge clk); start = 1'b0;
        if (poke && p != '0) begin start = 1'b1; pattern = ~p; end   // R10
        c = 0;
        while (!done && c < NN + 3) begin
            @(negedge clk); start = 1'b0; c++;
        end
        start = 1'b0;
        check(done, {tag, " R5 done seen"}, int'(done), 1);
        check(c == elat, {tag, " R5 latency"}, c, elat);
        check(cluster_ok == eok, {tag, " R4/R7 ok"}, int'(cluster_ok), int'(eok));
        if (eok) check(int'(cluster_id) == eid, {tag, " R3/R6 id"}, int'(cluster_id), eid);
        @(negedge clk);
        check(!done, {tag, " R12 strobe"}, int'(done), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit [NB-1:0] proto [6];
        void'($urandom(32'h5EED_A11C));
        do_reset();
        // R1: first vector to node 0 in one cycle
        run_vec(8'hFF, 0, "R1 first");
        run_vec(8'h00, 0, "R8 zero");
        run_vec(8'hFF, 1, "R10 poke");
        run_vec(8'h0F, 0, "R6 shrink");          // R11 template drops bits
        run_vec(8'hF0, 0, "R3 tie");             // nodes 1..3 tie
        run_vec(8'hFF, 0, "R11 no regrow");
        run_vec(8'h3C, 0, "R2 score");
        run_vec(8'hC3, 0, "R7 fill");
        run_vec(8'hA5, 1, "R7 all barred");
        run_vec(8'h0F, 0, "R9 after reject");
        for (int k = 0; k < 6; k++) proto[k] = NB'($urandom);
        for (int n = 0; n < 300; n++) begin
            bit [NB-1:0] v;
            if (n % 50 == 49) begin
                do_reset();
                for (int k = 0; k < 6; k++) proto[k] = NB'($urandom);
            end
            v = proto[$urandom % 6];
            if ($urandom % 3 == 0) v = v & NB'($urandom | $urandom);
            if ($urandom % 10 == 0) v = NB'($urandom);
            run_vec(v, ($urandom % 4) == 0, "rand");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule